// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This block executes the rotate-right group of a 64-bit integer pipeline. Each cycle it receives a 32-bit instruction word, the operand to rotate and a register that can supply the rotate amount. It decodes five forms: a 32-bit rotate by an immediate, a 32-bit rotate by a register amount, a 64-bit rotate by an immediate, a 64-bit rotate by the immediate plus 32, and a 64-bit rotate by a register amount. On the next rising clock edge it presents the rotated value, a write enable and the destination register index.

All five forms share one 64-bit rotator. For the 32-bit forms the low word is copied into both halves of the rotator input, and the low half of the output is then sign-extended from bit 31. A word that does not match one of the five encodings exactly, including its fixed `00001` field, is flagged as not decoded. It produces no write and leaves the held result unchanged. A build parameter selects either a logarithmic barrel or a double-width shifter as the rotator.

Top module: `rot_unit`

## Requirements
- R1: When bits [31:26] are 0, bits [5:0] are 000010 and bits [25:21] are 00001, the unit rotates `src_val[31:0]` right by bits [10:6].
- R2: When bits [5:0] are 000110 and bits [10:6] are 00001, the unit rotates `src_val[31:0]` right by `amt_reg[4:0]`. The upper bits of `amt_reg` have no effect.
- R3: When bits [5:0] are 111010 and bits [25:21] are 00001, the unit rotates all 64 bits of `src_val` right by bits [10:6].
- R4: When bits [5:0] are 111110 and bits [25:21] are 00001, the unit rotates all 64 bits right by bits [10:6] plus 32.
- R5: When bits [5:0] are 010110 and bits [10:6] are 00001, the unit rotates all 64 bits right by `amt_reg[5:0]`.
- R6: For the two 32-bit forms, result bits [63:32] are copies of result bit 31.
- R7: A rotate amount of zero returns the operand unchanged. For the 32-bit forms the low word is also sign-extended.
- R8: These cases give `dec_ok` = 0 and `wr_en` = 0 and leave `result` unchanged: bits [31:26] are not zero, the function code is none of the five, or the fixed 00001 field of the form does not match.
- R9: The outputs are registered and change only on the rising edge after the inputs are presented. When `op_valid` is 0, `wr_en` is 0 and `result` holds its value, while `dec_ok` still reports the decode result.
- R10: While `rst_n` is low, `result`, `wr_en`, `dec_ok` and `dest_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction word is issued this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | XLEN (64) | Operand to rotate |
| amt_reg | input | XLEN (64) | Register supplying the variable amount |
| result | output | XLEN (64) | Registered rotate result |
| wr_en | output | 1 | Registered write enable |
| dec_ok | output | 1 | Registered decode-valid flag |
| dest_idx | output | 5 | Registered destination index, bits [15:11] |

## Verification
Two things can happen in the same cycle: a word is rejected, or issued with `op_valid` low, and the result register must keep the value from the previous good write. The bench places malformed words right after good ones, with a corrupted fixed field, an unknown function code or a non-zero major opcode. It then checks that `result` still equals the expected value from the earlier write while `dec_ok` and `wr_en` drop. A second same-cycle case is an issued word with `op_valid` low. There `dec_ok` must rise while the write is suppressed and the held result stays unchanged.

// File: rtl/rot_pkg.sv
package rot_pkg;

   localparam int INSTR_W = 32;
   localparam int FLD_W   = 5;
   localparam int FN_W    = 6;
   localparam int MAJ_W   = 6;

   localparam logic [FLD_W-1:0] FIXED_MARK = 5'b00001;

   localparam logic [FN_W-1:0] FN_R32_IMM   = 6'b000010;
   localparam logic [FN_W-1:0] FN_R32_REG   = 6'b000110;
   localparam logic [FN_W-1:0] FN_R64_IMM   = 6'b111010;
   localparam logic [FN_W-1:0] FN_R64_IMMHI = 6'b111110;
   localparam logic [FN_W-1:0] FN_R64_REG   = 6'b010110;

   typedef enum logic [2:0] {
      K_NONE,
      K_R32_IMM,
      K_R32_REG,
      K_R64_IMM,
      K_R64_IMMHI,
      K_R64_REG
   } rot_kind_e;

endpackage

// File: rtl/rot_decode.sv
module rot_decode
   import rot_pkg::*;
#(
   parameter int AMT_W = 6
) (
   input  logic [MAJ_W-1:0] major,
   input  logic [FLD_W-1:0] rs_fld,
   input  logic [FLD_W-1:0] sa_fld,
   input  logic [FN_W-1:0]  fn,
   input  logic [AMT_W-1:0] reg_amt,
   output logic             valid,
   output logic             wide,
   output logic [AMT_W-1:0] amt,
   output rot_kind_e        kind
);

   localparam int PAD_W = AMT_W - FLD_W;

   logic rs_fixed;
   logic sa_fixed;
   logic maj_zero;

   assign rs_fixed = (rs_fld == FIXED_MARK);
   assign sa_fixed = (sa_fld == FIXED_MARK);
   assign maj_zero = (major == '0);

   always_comb begin
      kind = K_NONE;
      if (maj_zero) begin
         unique case (fn)
            FN_R32_IMM:   if (rs_fixed) kind = K_R32_IMM;
            FN_R32_REG:   if (sa_fixed) kind = K_R32_REG;
            FN_R64_IMM:   if (rs_fixed) kind = K_R64_IMM;
            FN_R64_IMMHI: if (rs_fixed) kind = K_R64_IMMHI;
            FN_R64_REG:   if (sa_fixed) kind = K_R64_REG;
            default:      kind = K_NONE;
         endcase
      end
   end

   always_comb begin
      amt = '0;
      unique case (kind)
         K_R32_IMM:   amt = {{PAD_W{1'b0}}, sa_fld};
         K_R32_REG:   amt = {{PAD_W{1'b0}}, reg_amt[FLD_W-1:0]};
         K_R64_IMM:   amt = {{PAD_W{1'b0}}, sa_fld};
         K_R64_IMMHI: amt = {{(PAD_W-1){1'b0}}, 1'b1, sa_fld};
         K_R64_REG:   amt = reg_amt;
         default:     amt = '0;
      endcase
   end

   assign valid = (kind != K_NONE);
   assign wide  = (kind == K_R64_IMM) || (kind == K_R64_IMMHI) || (kind == K_R64_REG);

   // R4
   always_comb begin
      if (!$isunknown(kind) && kind == K_R64_IMMHI)
         immhi_top_chk: assert (amt[AMT_W-1] == 1'b1);
   end

   // R8
   always_comb begin
      if (!$isunknown(valid) && valid)
         major_zero_chk: assert (major == '0);
   end

endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
   parameter int W     = 64,
   parameter int STYLE = 0,
   localparam int AW   = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);

   if (W < 2 || (1 << AW) != W) begin : g_w_chk
      $error("rot_barrel: W must be a power of two");
   end

   if (STYLE == 0) begin : g_log
      logic [W-1:0] stage [0:AW];
      assign stage[0] = din;
      for (genvar g = 0; g < AW; g++) begin : g_stage
         localparam int STEP = 1 << g;
         assign stage[g+1] = amt[g]
            ? {stage[g][STEP-1:0], stage[g][W-1:STEP]}
            : stage[g];
      end
      assign dout = stage[AW];
   end else begin : g_funnel
      logic [2*W-1:0] dbl;
      assign dbl  = {din, din} >> amt;
      assign dout = dbl[W-1:0];
   end

   // R7
   always_comb begin
      if (!$isunknown(amt) && !$isunknown(din) && amt == '0)
         zero_amt_chk: assert (dout == din);
   end

endmodule

// File: rtl/rot_unit.sv
module rot_unit
   import rot_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [XLEN-1:0]    src_val,
   input  logic [XLEN-1:0]    amt_reg,
   output logic [XLEN-1:0]    result,
   output logic               wr_en,
   output logic               dec_ok,
   output logic [FLD_W-1:0]   dest_idx
);

   localparam int HALF  = XLEN / 2;
   localparam int AMT_W = $clog2(XLEN);

   if (XLEN != 64) begin : g_xlen_chk
      $error("rot_unit: XLEN must be 64");
   end
   if ($clog2(HALF) != FLD_W || AMT_W != FLD_W + 1) begin : g_amt_chk
      $error("rot_unit: amount field widths do not match XLEN");
   end
   if (STYLE != 0 && STYLE != 1) begin : g_style_chk
      $error("rot_unit: STYLE must be 0 or 1");
   end

   logic             d_valid;
   logic             d_wide;
   logic [AMT_W-1:0] d_amt;
   rot_kind_e        d_kind;
   logic [XLEN-1:0]  rot_in;
   logic [XLEN-1:0]  rot_out;
   logic [XLEN-1:0]  wb_val;
   logic             issue;

   logic [XLEN-1:0]  result_q;
   logic             wr_q;
   logic             ok_q;
   logic             wide_q;
   logic [FLD_W-1:0] dest_q;

   logic unused_fields;
   assign unused_fields = ^{instr[20:16], amt_reg[XLEN-1:AMT_W], d_kind};

   rot_decode #(.AMT_W(AMT_W)) u_dec (
      .major   (instr[31:26]),
      .rs_fld  (instr[25:21]),
      .sa_fld  (instr[10:6]),
      .fn      (instr[5:0]),
      .reg_amt (amt_reg[AMT_W-1:0]),
      .valid   (d_valid),
      .wide    (d_wide),
      .amt     (d_amt),
      .kind    (d_kind)
   );

   assign rot_in = d_wide ? src_val : {src_val[HALF-1:0], src_val[HALF-1:0]};

   rot_barrel #(.W(XLEN), .STYLE(STYLE)) u_rot (
      .din  (rot_in),
      .amt  (d_amt),
      .dout (rot_out)
   );

   assign wb_val = d_wide ? rot_out : {{HALF{rot_out[HALF-1]}}, rot_out[HALF-1:0]};
   assign issue  = op_valid && d_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         wr_q     <= 1'b0;
         ok_q     <= 1'b0;
         wide_q   <= 1'b0;
         dest_q   <= '0;
      end else begin
         ok_q <= d_valid;
         wr_q <= issue;
         if (issue) begin
            result_q <= wb_val;
            wide_q   <= d_wide;
            dest_q   <= instr[15:11];
         end
      end
   end

   assign result   = result_q;
   assign wr_en    = wr_q;
   assign dec_ok   = ok_q;
   assign dest_idx = dest_q;

   // R8
   wr_needs_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> dec_ok);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> $stable(result));

   // R9
   issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && d_valid) |=> wr_en);

   // R6
   sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wide_q) |-> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));

   // R1
   mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_wide) |-> (rot_out[XLEN-1:HALF] == rot_out[HALF-1:0]));

endmodule

// File: tb/sim_rot_unit.sv
`timescale 1ns/1ps
module sim_rot_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] src_val = '0;
   logic [63:0] amt_reg = '0;
   logic [63:0] result;
   logic        wr_en;
   logic        dec_ok;
   logic [4:0]  dest_idx;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   rot_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
      .src_val(src_val), .amt_reg(amt_reg), .result(result),
      .wr_en(wr_en), .dec_ok(dec_ok), .dest_idx(dest_idx)
   );

   function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] rsf,
                                      input logic [4:0] rdf, input logic [4:0] saf,
                                      input logic [5:0] fnc);
      return {maj, rsf, 5'd2, rdf, saf, fnc};
   endfunction

   typedef struct packed {
      logic [31:0] ins;
      logic [63:0] a;
      logic [63:0] b;
      logic        ok;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{mk(6'd0, 5'd1, 5'd3,  5'd8,  6'b000010), 64'hFFFF_FFFF_1234_5678, 64'h0, 1'b1},
      '{mk(6'd0, 5'd1, 5'd4,  5'd4,  6'b000010), 64'h0000_0000_0000_000F, 64'h0, 1'b1},
      '{mk(6'd0, 5'd5, 5'd5,  5'd1,  6'b000110), 64'h0F0F_0000_8765_4321, 64'hFFFF_FFFF_FFFF_FFE3, 1'b1},
      '{mk(6'd0, 5'd1, 5'd6,  5'd12, 6'b111010), 64'h0123_4567_89AB_CDEF, 64'h0, 1'b1},
      '{mk(6'd0, 5'd1, 5'd7,  5'd0,  6'b111110), 64'hDEAD_BEEF_0000_0001, 64'h0, 1'b1},
      '{mk(6'd0, 5'd1, 5'd8,  5'd31, 6'b111110), 64'h8000_0000_0000_0001, 64'h0, 1'b1},
      '{mk(6'd0, 5'd9, 5'd9,  5'd1,  6'b010110), 64'hF000_0000_0000_000F, 64'h0000_0000_0000_00C5, 1'b1},
      '{mk(6'd0, 5'd9, 5'd10, 5'd1,  6'b010110), 64'h0000_0000_0000_0001, 64'h0000_0000_0000_003F, 1'b1},
      '{mk(6'd0, 5'd1, 5'd11, 5'd0,  6'b111010), 64'hCAFE_F00D_1234_5678, 64'h0, 1'b1},
      '{mk(6'd0, 5'd3, 5'd12, 5'd1,  6'b000110), 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b1},
      '{mk(6'd0, 5'd2, 5'd13, 5'd5,  6'b111010), 64'h1111_2222_3333_4444, 64'h0, 1'b0},
      '{mk(6'd0, 5'd4, 5'd14, 5'd0,  6'b010110), 64'h5555_6666_7777_8888, 64'h7, 1'b0},
      '{mk(6'd0, 5'd1, 5'd15, 5'd3,  6'b000011), 64'h9999_AAAA_BBBB_CCCC, 64'h0, 1'b0},
      '{mk(6'd1, 5'd1, 5'd16, 5'd3,  6'b111010), 64'hDDDD_EEEE_FFFF_0000, 64'h0, 1'b0},
      '{mk(6'd0, 5'd0, 5'd17, 5'd7,  6'b000010), 64'h0000_0000_1357_9BDF, 64'h0, 1'b0},
      '{mk(6'd0, 5'd1, 5'd18, 5'd2,  6'b000110), 64'h2468_ACE0_1357_9BDF, 64'h3, 1'b0}
   };

   function automatic logic [63:0] rot64(input logic [63:0] v, input int k);
      logic [63:0] o;
      for (int i = 0; i < 64; i++) o[i] = v[(i + k) % 64];
      return o;
   endfunction

   function automatic logic [63:0] rot32x(input logic [31:0] v, input int k);
      logic [31:0] o;
      for (int i = 0; i < 32; i++) o[i] = v[(i + k) % 32];
      return {{32{o[31]}}, o};
   endfunction

   task automatic model(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] res, output string tag);
      res = '0;
      tag = "R8";
      if (ins[31:26] == 6'd0) begin
         case (ins[5:0])
            6'b000010: if (ins[25:21] == 5'd1) begin res = rot32x(a[31:0], int'(ins[10:6])); tag = "R1"; end
            6'b000110: if (ins[10:6] == 5'd1) begin res = rot32x(a[31:0], int'(b[4:0])); tag = "R2"; end
            6'b111010: if (ins[25:21] == 5'd1) begin res = rot64(a, int'(ins[10:6])); tag = "R3"; end
            6'b111110: if (ins[25:21] == 5'd1) begin res = rot64(a, int'(ins[10:6]) + 32); tag = "R4"; end
            6'b010110: if (ins[10:6] == 5'd1) begin res = rot64(a, int'(b[5:0])); tag = "R5"; end
            default: ;
         endcase
      end
   endtask

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic issue(input logic v, input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      op_valid = v;
      instr    = ins;
      src_val  = a;
      amt_reg  = b;
      @(posedge clk);
      #1;
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #2000000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      logic [63:0] held;
      logic [63:0] exp_r;
      string tg;

      // R10: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R10", "result", result, 64'h0);
      chk("R10", "wr_en", {63'h0, wr_en}, 64'h0);
      chk("R10", "dec_ok", {63'h0, dec_ok}, 64'h0);
      chk("R10", "dest_idx", {59'h0, dest_idx}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      held = 64'h0;

      for (int i = 0; i < NV; i++) begin
         model(VECS[i].ins, VECS[i].a, VECS[i].b, exp_r, tg);
         @(negedge clk);
         op_valid = 1'b1;
         instr    = VECS[i].ins;
         src_val  = VECS[i].a;
         amt_reg  = VECS[i].b;
         #2;
         // R9: nothing moves before the edge
         chk("R9", "pre-edge result", result, held);
         @(posedge clk);
         #1;
         chk(tg, "dec_ok", {63'h0, dec_ok}, {63'h0, VECS[i].ok});
         chk(tg, "wr_en", {63'h0, wr_en}, {63'h0, VECS[i].ok});
         if (VECS[i].ok) begin
            held = exp_r;
            chk(tg, "dest_idx", {59'h0, dest_idx}, {59'h0, VECS[i].ins[15:11]});
         end
         chk(tg, "result", result, held);
      end

      // R9: decoded word with op_valid low
      issue(1'b0, mk(6'd0, 5'd1, 5'd20, 5'd9, 6'b111010), 64'hFFFF_0000_FFFF_0000, 64'h0);
      chk("R9", "dec_ok no issue", {63'h0, dec_ok}, 64'h1);
      chk("R9", "wr_en no issue", {63'h0, wr_en}, 64'h0);
      chk("R9", "result no issue", result, held);

      // R6: sign extension from bit 31
      issue(1'b1, mk(6'd0, 5'd1, 5'd21, 5'd4, 6'b000010), 64'h0000_0000_0000_000F, 64'h0);
      chk("R6", "result", result, 64'hFFFF_FFFF_F000_0000);

      // R4: immediate 0 plus 32 swaps the halves
      issue(1'b1, mk(6'd0, 5'd1, 5'd22, 5'd0, 6'b111110), 64'h0123_4567_89AB_CDEF, 64'h0);
      chk("R4", "result", result, 64'h89AB_CDEF_0123_4567);

      // R5: register amount 32 gives the same swap
      issue(1'b1, mk(6'd0, 5'd6, 5'd23, 5'd1, 6'b010110), 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFE0);
      chk("R5", "result", result, 64'h89AB_CDEF_0123_4567);

      // R2 R7: upper amount bits ignored, amount 0, sign extension
      issue(1'b1, mk(6'd0, 5'd6, 5'd24, 5'd1, 6'b000110), 64'h7777_7777_8000_0001, 64'hFFFF_FFFF_FFFF_FFE0);
      chk("R7", "result", result, 64'hFFFF_FFFF_8000_0001);

      // R8: bad word right after a good one keeps the result
      issue(1'b1, mk(6'd0, 5'd1, 5'd25, 5'd0, 6'b111111), 64'h0, 64'h0);
      chk("R8", "result after reject", result, 64'hFFFF_FFFF_8000_0001);
      chk("R8", "wr_en after reject", {63'h0, wr_en}, 64'h0);

      // R10: reset in mid-run clears outputs
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R10", "result in reset", result, 64'h0);
      chk("R10", "dec_ok in reset", {63'h0, dec_ok}, 64'h0);

      summary();
   end

endmodule